// File: doc/BRIEF.md
# Synthesizer Tuning Register Slave (I2C)

This block sits behind a two-wire I2C port and holds the settings of a frequency synthesizer: a 15-bit loop divider word, a control register and a 4-bit band-select register. A bus master addresses it with a fixed 5-bit device identifier followed by two strap bits taken from board-level inputs. In a write, the master sends any number of byte groups. Each byte's top bit selects its meaning. A frequency group is two bytes. A control group is a control byte followed by a band byte. Each group commits on its own.

In a read, the block returns a status byte. This byte carries a power-on flag, the loop lock flag and a 3-bit level code from an external comparator ladder. The power-on flag stays set until a status byte has been shifted out. The master may acknowledge to receive a fresh status byte again, or send a not-acknowledge to end the read. SCL and SDA are oversampled on the system clock. SDA is driven open-drain through an output enable.

Top module: `synth_i2c_regs`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte equal to binary 11000, then strap[1], strap[0], then the R/W bit, sent MSB first. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write, every data byte after a matching address is acknowledged.
- R3: A data byte whose MSB is 0 is the upper frequency byte: bits 6..0 become div_word[14:8]. The next byte becomes div_word[7:0]. Both halves update together once the second byte is complete.
- R4: A data byte whose MSB is 1, outside a pending group, is the control byte. Bit 6 drives ctl_cp, bits 5..3 drive ctl_test[2:0], bit 2 drives ctl_rs_a, bit 1 drives ctl_rs_b and bit 0 drives ctl_os. These outputs update when that byte completes.
- R5: The byte that follows a control byte is the band byte, whatever its MSB. Its bits 3..0 become band[3:0] and its bits 7..4 have no effect.
- R6: Several groups may follow a single address. Each group commits independently until a STOP.
- R7: A STOP after only the upper frequency byte leaves div_word unchanged, and values committed earlier stay in force.
- R8: A read returns, MSB first, the byte {por flag, lock_in, 1, 1, 1, level_code[2:0]}. The level codes 000..100 run from the lowest to the highest input band.
- R9: The power-on flag is 1 after reset and after a por_evt pulse. It is cleared once a status byte has been completely sent.
- R10: After a status byte, a master acknowledge makes the block send a newly sampled status byte. A master not-acknowledge makes it release SDA and go idle.
- R11: A repeated START restarts address reception and discards a half-received frequency pair.
- R12: After reset: div_word is 0, band is 0, ctl_cp is 0, ctl_test is 001, ctl_rs_a and ctl_rs_b are 1, ctl_os is 0, and sda_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level (wired bus value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap | input | 2 | Address strap bits |
| lock_in | input | 1 | Loop lock indicator, 1 = locked |
| level_code | input | 3 | Comparator ladder code, 000..100 |
| por_evt | input | 1 | Pulse that sets the power-on flag |
| div_word | output | 15 | Loop divider ratio |
| ctl_cp | output | 1 | Charge pump current select |
| ctl_test | output | 3 | Test mode code |
| ctl_rs_a | output | 1 | Reference divider select, first bit |
| ctl_rs_b | output | 1 | Reference divider select, second bit |
| ctl_os | output | 1 | Tuning amplifier disable |
| band | output | 4 | Band switch enables |

## Verification
Most internal faults in the byte-type tracking show up at the register outputs as soon as the stop of the transfer that exercised them. Examples are a pending-pair flag left set, or a band slot expected after the wrong byte: the wrong field is loaded, or the wrong half of div_word is loaded. A wrong bit count or a broken acknowledge path appears within one byte time as a missing or misplaced SDA pull. A stale or mis-ordered status byte, or a power-on flag that never clears, appears on the very next read.

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs #(
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] DEV_ID = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [1:0]  strap,
  input  logic        lock_in,
  input  logic [2:0]  level_code,
  input  logic        por_evt,
  output logic [14:0] div_word,
  output logic        ctl_cp,
  output logic [2:0]  ctl_test,
  output logic        ctl_rs_a,
  output logic        ctl_rs_b,
  output logic        ctl_os,
  output logic [3:0]  band
);

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WDATA, WACK, RDATA, RACK} st_t;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  st_t  st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [1:0] wsub;
  logic [6:0] hi_q, ctl_q;
  logic [14:0] div_q;
  logic [3:0] band_q;
  logic por, mack, oe;

  wire scl_s = scl_pipe[SYNC_STAGES-1];
  wire sda_s = sda_pipe[SYNC_STAGES-1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_evt = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] status = {por, lock_in, 3'b111, level_code};
  wire addr_hit = (sh[7:1] == {DEV_ID, strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      wsub   <= '0;
      hi_q   <= '0;
      ctl_q  <= 7'b0_001_110;
      div_q  <= '0;
      band_q <= '0;
      por    <= 1'b1;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (start_evt) begin
        st   <= ADDR;
        cnt  <= '0;
        oe   <= 1'b0;
        wsub <= '0;
      end else if (stop_evt) begin
        st   <= IDLE;
        oe   <= 1'b0;
        wsub <= '0;
      end else begin
        case (st)
          ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_hit) begin
                oe <= 1'b1;
                st <= AACK;
              end else begin
                st <= IDLE;
              end
            end
          end
          AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (sh[0]) begin
                tx <= status;
                oe <= ~status[7];
                st <= RDATA;
              end else begin
                oe <= 1'b0;
                st <= WDATA;
              end
            end
          end
          WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              oe <= 1'b1;
              st <= WACK;
              if (wsub == 2'd1) begin
                div_q <= {hi_q, sh};
                wsub  <= 2'd0;
              end else if (wsub == 2'd2) begin
                band_q <= sh[3:0];
                wsub   <= 2'd0;
              end else if (!sh[7]) begin
                hi_q <= sh[6:0];
                wsub <= 2'd1;
              end else begin
                ctl_q <= sh[6:0];
                wsub  <= 2'd2;
              end
            end
          end
          WACK: begin
            if (scl_fall) begin
              oe  <= 1'b0;
              cnt <= '0;
              st  <= WDATA;
            end
          end
          RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe  <= 1'b0;
                por <= 1'b0;
                st  <= RACK;
              end else begin
                oe <= ~tx[6];
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx  <= status;
                oe  <= ~status[7];
                cnt <= '0;
                st  <= RDATA;
              end else begin
                st <= IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (por_evt) por <= 1'b1;
    end
  end

  assign sda_oe   = oe;
  assign div_word = div_q;
  assign band     = band_q;
  assign ctl_cp   = ctl_q[6];
  assign ctl_test = ctl_q[5:3];
  assign ctl_rs_a = ctl_q[2];
  assign ctl_rs_b = ctl_q[1];
  assign ctl_os   = ctl_q[0];

endmodule

// File: rtl/synth_i2c_regs_chk.sv
module synth_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_fall,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        sda_oe,
  input logic [14:0] div_word,
  input logic [6:0]  ctl_bits,
  input logic [3:0]  band
);

  // R2
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_word) |-> $past(scl_fall));

  // R4
  ctl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_bits) |-> $past(scl_fall));

  // R5
  band_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band) |-> $past(scl_fall));

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R3
  div_quiet_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> $stable(div_word));

endmodule

bind synth_i2c_regs synth_i2c_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_fall (scl_fall),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .sda_oe   (sda_oe),
  .div_word (div_word),
  .ctl_bits ({ctl_cp, ctl_test, ctl_rs_a, ctl_rs_b, ctl_os}),
  .band     (band)
);

// File: tb/synth_i2c_regs_test.sv
module synth_i2c_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic md = 1'b1;
  logic lock_in = 1'b0;
  logic [2:0] level_code = 3'd0;
  logic por_evt = 1'b0;
  logic sda_oe, ctl_cp, ctl_rs_a, ctl_rs_b, ctl_os;
  logic [2:0] ctl_test;
  logic [14:0] div_word;
  logic [3:0] band;
  wire sda_bus = md & ~sda_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [14:0] exp_div = '0;
  logic [6:0]  exp_ctl = 7'b0_001_110;
  logic [3:0]  exp_band = '0;
  logic        exp_por = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_i2c_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap(STRAP), .lock_in(lock_in), .level_code(level_code), .por_evt(por_evt),
    .div_word(div_word), .ctl_cp(ctl_cp), .ctl_test(ctl_test), .ctl_rs_a(ctl_rs_a),
    .ctl_rs_b(ctl_rs_b), .ctl_os(ctl_os), .band(band)
  );

  function automatic logic [7:0] status_exp(input logic p, input logic l, input logic [2:0] c);
    return {p, l, 3'b111, c};
  endfunction

  function automatic logic [7:0] addr_byte(input logic rw);
    return {5'b11000, STRAP, rw};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    md = b; waitq();
    scl = 1'b1; waitq();
    r = sda_bus; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic i2c_start();
    md = 1'b1; waitq();
    scl = 1'b1; waitq();
    md = 1'b0; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    md = 1'b0; waitq();
    scl = 1'b1; waitq();
    md = 1'b1; waitq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic master_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(~master_ack, r);
  endtask

  task automatic check_regs(input string req);
    check(div_word == exp_div, req, {17'd0, div_word}, {17'd0, exp_div});
    check({ctl_cp, ctl_test, ctl_rs_a, ctl_rs_b, ctl_os} == exp_ctl, req,
          {25'd0, ctl_cp, ctl_test, ctl_rs_a, ctl_rs_b, ctl_os}, {25'd0, exp_ctl});
    check(band == exp_band, req, {28'd0, band}, {28'd0, exp_band});
  endtask

  task automatic do_read(input logic l, input logic [2:0] c, input string req);
    logic ack;
    logic [7:0] b;
    lock_in = l; level_code = c;
    i2c_start();
    wbyte(addr_byte(1'b1), ack);
    check(ack, "R1 read address ack", {31'd0, ack}, 32'd1);
    rbyte(1'b0, b);
    check(b == status_exp(exp_por, l, c), req, {24'd0, b}, {24'd0, status_exp(exp_por, l, c)});
    exp_por = 1'b0;
    i2c_stop();
    check(!sda_oe, "R10 released after NACK", {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    logic ack;
    logic [7:0] b, b2;
    int seed_v;
    seed_v = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check_regs("R12 reset values");
    check(!sda_oe, "R12 sda released", {31'd0, sda_oe}, 32'd0);

    // R8 / R9 first read shows power-on flag, second shows it cleared
    do_read(1'b1, 3'd3, "R8 R9 status after reset");
    do_read(1'b0, 3'd4, "R9 flag cleared after read");

    // R1 R2 R3 frequency pair
    i2c_start();
    wbyte(addr_byte(1'b0), ack);
    check(ack, "R1 write address ack", {31'd0, ack}, 32'd1);
    wbyte(8'h2A, ack);
    check(ack, "R2 data ack hi", {31'd0, ack}, 32'd1);
    wbyte(8'h5C, ack);
    check(ack, "R2 data ack lo", {31'd0, ack}, 32'd1);
    exp_div = 15'h2A5C;
    i2c_stop();
    check_regs("R3 frequency pair");

    // R4 R5 R6 control + band with junk high nibble, then another pair
    i2c_start();
    wbyte(addr_byte(1'b0), ack);
    wbyte(8'hD3, ack); exp_ctl = 7'h53;
    wbyte(8'hF5, ack); exp_band = 4'h5;
    check(ack, "R2 band byte ack", {31'd0, ack}, 32'd1);
    wbyte(8'h01, ack);
    wbyte(8'hFF, ack); exp_div = 15'h01FF;
    i2c_stop();
    check_regs("R4 R5 R6 grouped writes");

    // R7 abort after upper byte
    i2c_start();
    wbyte(addr_byte(1'b0), ack);
    wbyte(8'h7F, ack);
    i2c_stop();
    check_regs("R7 abort keeps old divider");

    // R1 wrong address ignored
    i2c_start();
    wbyte({5'b11000, ~STRAP, 1'b0}, ack);
    check(!ack, "R1 mismatch not acked", {31'd0, ack}, 32'd0);
    wbyte(8'h11, ack);
    wbyte(8'h22, ack);
    i2c_stop();
    check_regs("R1 mismatch ignored");

    // R11 repeated start drops half pair
    i2c_start();
    wbyte(addr_byte(1'b0), ack);
    wbyte(8'h33, ack);
    i2c_start();
    wbyte(addr_byte(1'b0), ack);
    check(ack, "R11 address after restart", {31'd0, ack}, 32'd1);
    wbyte(8'h44, ack);
    wbyte(8'h07, ack);
    exp_div = 15'h4407;
    i2c_stop();
    check_regs("R11 restart");

    // R10 R9 master ACK repeats status, flag cleared after first
    @(negedge clk); por_evt = 1'b1; @(negedge clk); por_evt = 1'b0;
    lock_in = 1'b1; level_code = 3'd2;
    i2c_start();
    wbyte(addr_byte(1'b1), ack);
    rbyte(1'b1, b);
    rbyte(1'b0, b2);
    i2c_stop();
    check(b == status_exp(1'b1, 1'b1, 3'd2), "R9 por_evt sets flag", {24'd0, b}, {24'd0, status_exp(1'b1, 1'b1, 3'd2)});
    check(b2 == status_exp(1'b0, 1'b1, 3'd2), "R10 repeated status", {24'd0, b2}, {24'd0, status_exp(1'b0, 1'b1, 3'd2)});
    exp_por = 1'b0;

    // random mix
    for (int it = 0; it < 30; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        do_read(1'($urandom_range(0, 1)), 3'($urandom_range(0, 4)), "R8 random status");
      end else begin
        i2c_start();
        wbyte(addr_byte(1'b0), ack);
        for (int g = 0; g < int'($urandom_range(1, 3)); g++) begin
          b = 8'($urandom());
          if ($urandom_range(0, 1) == 0) begin
            b[7] = 1'b0;
            wbyte(b, ack);
            b2 = 8'($urandom());
            wbyte(b2, ack);
            exp_div = {b[6:0], b2};
          end else begin
            b[7] = 1'b1;
            wbyte(b, ack);
            exp_ctl = b[6:0];
            b2 = 8'($urandom());
            wbyte(b2, ack);
            exp_band = b2[3:0];
          end
          check(ack, "R2 random ack", {31'd0, ack}, 32'd1);
        end
        if ($urandom_range(0, 3) == 0) begin
          b = 8'($urandom());
          b[7] = 1'b0;
          wbyte(b, ack);
        end
        i2c_stop();
        check_regs("R6 R7 random writes");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule